// File: doc/BRIEF.md
# Power-Mode Clock Source Controller

This block decides which oscillators run and which one drives the system clock, based on the power-managed mode that software has chosen. Seven modes are recognised: primary run and idle, secondary run and idle, internal-RC run and idle, and sleep. In the two internal-RC modes a select bit picks the clock. It comes either straight from the 31 kHz low-frequency RC or from the 8 MHz internal oscillator through a postscaler, whose ratio is passed on as a code.

On top of the mode, three side needs keep oscillators alive. The watchdog needs the 31 kHz RC. Timer1 and Timer3 may need the secondary (Timer1) oscillator. Two-speed start-up needs the 8 MHz oscillator, set to 1 MHz, for a fixed window after reset and after a wake from sleep when that feature is configured. The mode and the side-need flags are captured in registers at each clock edge, and all outputs follow from that registered state. A change at the inputs therefore shows at the outputs after the next rising edge.

Top module: `pmcc_top`

## Requirements
- R1: The primary oscillator enable is high exactly when the registered mode is primary run (code 0) or primary idle (code 1), and clk_sel is then 1.
- R2: In secondary run (code 2) and secondary idle (code 3) the secondary oscillator enable is high and clk_sel is 2.
- R3: When t1_osc_req is high, the secondary oscillator enable is high after the next edge in every mode, sleep included. Outside the secondary modes it otherwise stays low.
- R4: In internal-RC run (code 4) or idle (code 5) with rc_direct high, the low-frequency RC enable is high and clk_sel is 3. Outside the start-up window the 8 MHz oscillator enable is low.
- R5: In internal-RC run or idle with rc_direct low, the 8 MHz oscillator enable is high, clk_sel is 4, and ratio_out equals the registered ratio_sel outside the start-up window.
- R6: For BOOST_LEN cycles (default 16) after reset is released, the 8 MHz enable is high and ratio_out is BOOST_RATIO (default 3, the 1 MHz setting), whatever the mode. The same window restarts when wake_evt is high at an edge while the registered mode is sleep and two_speed_en is high.
- R7: A wake_evt with two_speed_en low, or a wake_evt outside sleep, does not open a start-up window.
- R8: In sleep (code 6) clk_sel is 0 and the primary oscillator is off. The low-frequency RC runs only for the watchdog, the secondary oscillator only for t1_osc_req, and the 8 MHz oscillator only inside a start-up window.
- R9: When wdt_en is high, the low-frequency RC enable is high after the next edge, in every mode.
- R10: Inputs are registered, so outputs change only after a rising edge. Mode code 7 is treated as primary run. Reset is synchronous and active low: it gives primary run with every flag cleared and the ratio at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Requested power-managed mode code |
| wdt_en | input | 1 | Watchdog enabled, needs low-frequency RC |
| t1_osc_req | input | 1 | Timer1/Timer3 need the secondary oscillator |
| rc_direct | input | 1 | Internal-RC modes: 1 = clock from 31 kHz RC, 0 = from postscaled 8 MHz |
| ratio_sel | input | RATIO_W | Requested postscaler ratio code |
| two_speed_en | input | 1 | Two-speed start-up configured |
| wake_evt | input | 1 | Wake-from-sleep event |
| pri_osc_en | output | 1 | Primary oscillator enable |
| sec_osc_en | output | 1 | Secondary (Timer1) oscillator enable |
| lfrc_osc_en | output | 1 | 31 kHz RC enable |
| hfint_osc_en | output | 1 | 8 MHz internal oscillator enable |
| clk_sel | output | 3 | Clock mux code: 0 none, 1 primary, 2 secondary, 3 low-freq RC, 4 postscaled internal |
| ratio_out | output | RATIO_W | Postscaler ratio code in force |

## Verification
The assertions take mode_sel, wdt_en and t1_osc_req as synchronous inputs that are stable around the rising edge. They also assume no property starts while reset is held, since every registered flag is then cleared. The bench changes every input only on the falling edge. It pulses wake_evt both inside and outside sleep, and with two_speed_en both set and clear. This exercises the start-up window on legal paths and on paths that should be ignored.

// File: rtl/pmcc_pkg.sv
// Package: shared mode and clock-source encodings for the power-mode
// clock source controller. Assumes 3-bit codes on both sides.
package pmcc_pkg;

    localparam int MODE_W = 3;
    localparam int SEL_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_PRI_RUN  = 3'd0,
        PM_PRI_IDLE = 3'd1,
        PM_SEC_RUN  = 3'd2,
        PM_SEC_IDLE = 3'd3,
        PM_RC_RUN   = 3'd4,
        PM_RC_IDLE  = 3'd5,
        PM_SLEEP    = 3'd6
    } pm_mode_e;

    typedef enum logic [SEL_W-1:0] {
        CS_NONE  = 3'd0,
        CS_PRI   = 3'd1,
        CS_SEC   = 3'd2,
        CS_LFRC  = 3'd3,
        CS_HFINT = 3'd4
    } clk_src_e;

    localparam logic [MODE_W-1:0] MODE_ILLEGAL = 3'd7;

endpackage

// File: rtl/pmcc_ctrl_reg.sv
// Control register: captures the requested mode and the side-need flags
// on each clock edge. An unknown mode code falls back to primary run.
// Assumes synchronous inputs; synchronous active-low reset.
module pmcc_ctrl_reg
    import pmcc_pkg::*;
#(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  mode_sel,
    input  logic               wdt_en,
    input  logic               t1_osc_req,
    input  logic               rc_direct,
    input  logic [RATIO_W-1:0] ratio_sel,
    output pm_mode_e           mode_q,
    output logic               wdt_q,
    output logic               t1_q,
    output logic               direct_q,
    output logic [RATIO_W-1:0] ratio_q
);

    pm_mode_e mode_d;

    // Map the raw request to a legal mode.
    always_comb begin
        if (mode_sel == MODE_ILLEGAL) begin
            mode_d = PM_PRI_RUN;
        end else begin
            mode_d = pm_mode_e'(mode_sel);
        end
    end

    // Hold the registered control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= PM_PRI_RUN;
            wdt_q    <= 1'b0;
            t1_q     <= 1'b0;
            direct_q <= 1'b0;
            ratio_q  <= '0;
        end else begin
            mode_q   <= mode_d;
            wdt_q    <= wdt_en;
            t1_q     <= t1_osc_req;
            direct_q <= rc_direct;
            ratio_q  <= ratio_sel;
        end
    end

endmodule

// File: rtl/pmcc_boost_timer.sv
// Start-up window timer: counts BOOST_LEN cycles after reset, and again
// after a qualifying wake from sleep. Assumes BOOST_LEN >= 1.
module pmcc_boost_timer #(
    parameter int BOOST_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_sleep,
    input  logic two_speed_en,
    input  logic wake_evt,
    output logic boost
);

    localparam int CNT_W = $clog2(BOOST_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BOOST_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic             restart;

    // A wake restarts the window only from sleep with two-speed set.
    always_comb begin
        restart = wake_evt && two_speed_en && in_sleep;
    end

    // Load, count down and park at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_LOAD;
        end else if (restart) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The window is open while the count is non-zero.
    always_comb begin
        boost = (cnt_q != '0);
    end

endmodule

// File: rtl/pmcc_src_enables.sv
// Source enables: derives the four oscillator enables and the clock mux
// code from the registered mode, side-need flags and start-up window.
// Purely combinational; assumes registered inputs.
module pmcc_src_enables
    import pmcc_pkg::*;
(
    input  pm_mode_e          mode_q,
    input  logic              wdt_q,
    input  logic              t1_q,
    input  logic              direct_q,
    input  logic              boost,
    output logic              pri_en,
    output logic              sec_en,
    output logic              lfrc_en,
    output logic              hfint_en,
    output logic [SEL_W-1:0]  sel
);

    logic is_pri;
    logic is_sec;
    logic is_rc;
    clk_src_e src;

    // Classify the mode into families.
    always_comb begin
        is_pri = (mode_q == PM_PRI_RUN) || (mode_q == PM_PRI_IDLE);
        is_sec = (mode_q == PM_SEC_RUN) || (mode_q == PM_SEC_IDLE);
        is_rc  = (mode_q == PM_RC_RUN)  || (mode_q == PM_RC_IDLE);
    end

    // Combine the mode with the side needs into enables.
    always_comb begin
        pri_en   = is_pri;
        sec_en   = is_sec || t1_q;
        lfrc_en  = wdt_q || (is_rc && direct_q);
        hfint_en = boost || (is_rc && !direct_q);
    end

    // Pick the clock mux code; sleep selects nothing.
    always_comb begin
        unique case (mode_q)
            PM_PRI_RUN, PM_PRI_IDLE: src = CS_PRI;
            PM_SEC_RUN, PM_SEC_IDLE: src = CS_SEC;
            PM_RC_RUN,  PM_RC_IDLE:  src = direct_q ? CS_LFRC : CS_HFINT;
            default:                 src = CS_NONE;
        endcase
        sel = src;
    end

endmodule

// File: rtl/pmcc_ratio_ctrl.sv
// Ratio control: passes the requested postscaler code, overridden by the
// start-up setting while the window is open. Assumes BOOST_RATIO fits.
module pmcc_ratio_ctrl #(
    parameter int RATIO_W     = 3,
    parameter int BOOST_RATIO = 3
) (
    input  logic               boost,
    input  logic [RATIO_W-1:0] ratio_q,
    output logic [RATIO_W-1:0] ratio_out
);

    localparam logic [RATIO_W-1:0] BOOST_CODE = RATIO_W'(BOOST_RATIO);

    // Per-bit override mux.
    for (genvar i = 0; i < RATIO_W; i++) begin : g_bit
        assign ratio_out[i] = boost ? BOOST_CODE[i] : ratio_q[i];
    end

endmodule

// File: rtl/pmcc_top.sv
// Power-mode clock source controller top: registers the mode request and
// side needs, runs the start-up window and drives the oscillator enables,
// clock mux code and postscaler code. Synchronous active-low reset.
module pmcc_top
    import pmcc_pkg::*;
#(
    parameter int RATIO_W     = 3,
    parameter int BOOST_LEN   = 16,
    parameter int BOOST_RATIO = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_sel,
    input  logic               wdt_en,
    input  logic               t1_osc_req,
    input  logic               rc_direct,
    input  logic [RATIO_W-1:0] ratio_sel,
    input  logic               two_speed_en,
    input  logic               wake_evt,
    output logic               pri_osc_en,
    output logic               sec_osc_en,
    output logic               lfrc_osc_en,
    output logic               hfint_osc_en,
    output logic [2:0]         clk_sel,
    output logic [RATIO_W-1:0] ratio_out
);

    pm_mode_e           mode_q;
    logic               wdt_q;
    logic               t1_q;
    logic               direct_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               boost;
    logic               in_sleep;

    pmcc_ctrl_reg #(.RATIO_W(RATIO_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .wdt_en     (wdt_en),
        .t1_osc_req (t1_osc_req),
        .rc_direct  (rc_direct),
        .ratio_sel  (ratio_sel),
        .mode_q     (mode_q),
        .wdt_q      (wdt_q),
        .t1_q       (t1_q),
        .direct_q   (direct_q),
        .ratio_q    (ratio_q)
    );

    // Sleep flag for the wake qualifier.
    always_comb begin
        in_sleep = (mode_q == PM_SLEEP);
    end

    pmcc_boost_timer #(.BOOST_LEN(BOOST_LEN)) boost_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_sleep     (in_sleep),
        .two_speed_en (two_speed_en),
        .wake_evt     (wake_evt),
        .boost        (boost)
    );

    pmcc_src_enables en_i (
        .mode_q   (mode_q),
        .wdt_q    (wdt_q),
        .t1_q     (t1_q),
        .direct_q (direct_q),
        .boost    (boost),
        .pri_en   (pri_osc_en),
        .sec_en   (sec_osc_en),
        .lfrc_en  (lfrc_osc_en),
        .hfint_en (hfint_osc_en),
        .sel      (clk_sel)
    );

    pmcc_ratio_ctrl #(.RATIO_W(RATIO_W), .BOOST_RATIO(BOOST_RATIO)) ratio_i (
        .boost     (boost),
        .ratio_q   (ratio_q),
        .ratio_out (ratio_out)
    );

endmodule

// File: rtl/pmcc_checker.sv
// Checker: port-level properties of the clock source controller, bound
// to every instance of the top module.
module pmcc_checker #(
    parameter int RATIO_W     = 3,
    parameter int BOOST_RATIO = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         mode_sel,
    input logic               wdt_en,
    input logic               t1_osc_req,
    input logic               pri_osc_en,
    input logic               sec_osc_en,
    input logic               lfrc_osc_en,
    input logic               hfint_osc_en,
    input logic [2:0]         clk_sel,
    input logic [RATIO_W-1:0] ratio_out
);

    AST_PRI_ONLY_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        pri_osc_en |-> clk_sel == 3'd1); // R1
    AST_SEC_SELECTED_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel == 3'd2 |-> sec_osc_en); // R2
    AST_T1_REQ_KEEPS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        t1_osc_req |=> sec_osc_en); // R3
    AST_LFRC_SELECTED_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel == 3'd3 |-> lfrc_osc_en); // R4
    AST_HFINT_SELECTED_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel == 3'd4 |-> hfint_osc_en); // R5
    AST_RESET_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> hfint_osc_en && ratio_out == RATIO_W'(BOOST_RATIO)); // R6
    AST_SLEEP_PRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel == 3'd0 |-> !pri_osc_en); // R8
    AST_WDT_KEEPS_LFRC: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_en |=> lfrc_osc_en); // R9
    AST_ILLEGAL_TO_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 3'd7 |=> clk_sel == 3'd1); // R10

endmodule

bind pmcc_top pmcc_checker #(.RATIO_W(RATIO_W), .BOOST_RATIO(BOOST_RATIO)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .wdt_en       (wdt_en),
    .t1_osc_req   (t1_osc_req),
    .pri_osc_en   (pri_osc_en),
    .sec_osc_en   (sec_osc_en),
    .lfrc_osc_en  (lfrc_osc_en),
    .hfint_osc_en (hfint_osc_en),
    .clk_sel      (clk_sel),
    .ratio_out    (ratio_out)
);

// File: tb/pmcc_top_tb_top.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with every output on each falling edge.
module pmcc_top_tb_top;

    localparam int RW = 3;
    localparam int BLEN = 16;
    localparam int BRAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic wdt_en = 1'b0, t1_osc_req = 1'b0, rc_direct = 1'b0;
    logic [RW-1:0] ratio_sel = '0;
    logic two_speed_en = 1'b0, wake_evt = 1'b0;
    logic pri_osc_en, sec_osc_en, lfrc_osc_en, hfint_osc_en;
    logic [2:0] clk_sel;
    logic [RW-1:0] ratio_out;

    int errors = 0;
    int checks = 0;
    bit seen_edge = 0;
    bit done = 0;
    string phase = "R10 reset";

    // Model state
    int m_mode, m_ratio, m_cnt;
    bit m_wdt, m_t1, m_dir;

    pmcc_top #(.RATIO_W(RW), .BOOST_LEN(BLEN), .BOOST_RATIO(BRAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wdt_en(wdt_en),
        .t1_osc_req(t1_osc_req), .rc_direct(rc_direct), .ratio_sel(ratio_sel),
        .two_speed_en(two_speed_en), .wake_evt(wake_evt),
        .pri_osc_en(pri_osc_en), .sec_osc_en(sec_osc_en),
        .lfrc_osc_en(lfrc_osc_en), .hfint_osc_en(hfint_osc_en),
        .clk_sel(clk_sel), .ratio_out(ratio_out)
    );

    always #4 clk = ~clk;

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_wdt = 0; m_t1 = 0; m_dir = 0; m_ratio = 0; m_cnt = BLEN;
        end else begin
            if (wake_evt && two_speed_en && m_mode == 6) m_cnt = BLEN;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_mode  = (mode_sel == 3'd7) ? 0 : int'(mode_sel);
            m_wdt   = wdt_en;
            m_t1    = t1_osc_req;
            m_dir   = rc_direct;
            m_ratio = int'(ratio_sel);
        end
        seen_edge = 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, phase, what, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            bit boost, is_rc;
            int e_sel;
            boost = (m_cnt > 0);
            is_rc = (m_mode == 4) || (m_mode == 5);
            if (m_mode <= 1) e_sel = 1;
            else if (m_mode <= 3) e_sel = 2;
            else if (is_rc) e_sel = m_dir ? 3 : 4;
            else e_sel = 0;
            chk("R1", "pri_osc_en", int'(pri_osc_en), int'(m_mode <= 1));
            chk((m_t1 && !(m_mode == 2 || m_mode == 3)) ? "R3" : "R2", "sec_osc_en",
                int'(sec_osc_en), int'(m_mode == 2 || m_mode == 3 || m_t1));
            chk(m_wdt ? "R9" : "R4", "lfrc_osc_en", int'(lfrc_osc_en),
                int'(m_wdt || (is_rc && m_dir)));
            chk(boost ? "R6" : "R5", "hfint_osc_en", int'(hfint_osc_en),
                int'(boost || (is_rc && !m_dir)));
            chk(m_mode == 6 ? "R8" : "R10", "clk_sel", int'(clk_sel), e_sel);
            chk(boost ? "R6" : "R5", "ratio_out", int'(ratio_out), boost ? BRAT : m_ratio);
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        phase = "R6 start-up window after reset";
        step(BLEN + 4);

        phase = "R1 R2 R4 R5 R9 R3 mode sweep";
        for (int m = 0; m < 8; m++) begin
            for (int f = 0; f < 8; f++) begin
                mode_sel = 3'(m);
                rc_direct = f[0];
                wdt_en = f[1];
                t1_osc_req = f[2];
                ratio_sel = 3'(m + f);
                if (m == 7) phase = "R10 illegal mode code";
                step(2);
            end
        end

        phase = "R6 wake with two-speed";
        wdt_en = 0; t1_osc_req = 0; two_speed_en = 1; rc_direct = 1;
        mode_sel = 3'd6;
        step(4);
        wake_evt = 1; mode_sel = 3'd4;
        step(1);
        wake_evt = 0;
        step(BLEN + 3);

        phase = "R7 wake without two-speed";
        two_speed_en = 0; mode_sel = 3'd6;
        step(3);
        wake_evt = 1; mode_sel = 3'd5;
        step(1);
        wake_evt = 0;
        step(4);

        phase = "R7 wake outside sleep";
        two_speed_en = 1; mode_sel = 3'd4;
        step(2);
        wake_evt = 1;
        step(1);
        wake_evt = 0;
        step(4);

        phase = "R8 sleep with side needs";
        for (int f = 0; f < 4; f++) begin
            mode_sel = 3'd6; wdt_en = f[0]; t1_osc_req = f[1];
            step(3);
        end

        phase = "R10 random sequence";
        for (int i = 0; i < 3000; i++) begin
            mode_sel = 3'($urandom_range(0, 7));
            wdt_en = 1'($urandom);
            t1_osc_req = 1'($urandom);
            rc_direct = 1'($urandom);
            ratio_sel = 3'($urandom);
            two_speed_en = 1'($urandom);
            wake_evt = ($urandom_range(0, 5) == 0);
            if (i == 1500) rst_n = 1'b0;
            if (i == 1503) rst_n = 1'b1;
            step(1);
        end
        wake_evt = 0;
        step(2);
        summary();
        $finish;
    end

endmodule